// File: doc/BRIEF.md
# Return Gadget Chain Monitor

This block watches the stream of retired instructions from a processor core and flags behaviour typical of code-reuse attacks. It applies two coarse-grained rules. First, each return must land on an address that directly follows a call instruction. Software loads these addresses into a small on-chip table, so no shadow copy of return addresses is kept. Second, the monitor measures the length of each run of instructions that ends in an indirect branch. It raises an alarm when too many short runs occur back to back.

One trace beat is presented per cycle: a valid strobe, an instruction kind and the branch target. A run ("sequence") starts after an indirect branch and ends with the next indirect branch. Its length counts every instruction in it, including the closing branch. A sequence shorter than the length limit is gadget-like and advances a chain counter. A sequence at or above the limit resets that counter. Both limits can be written at run time. The first fault found sets a sticky flag and a cause code, and both hold until a clear pulse.

Top module: `rfg_top`

## Requirements
- R1: After reset, `viol` is 0 and `cause` is 0. Every call-site table entry is invalid. The length limit is 5 and the chain limit is 8.
- R2: A valid beat with `tr_kind`=2 (return) is legal, and raises nothing, when `tr_target` equals the address of any valid table entry.
- R3: A valid return whose target matches no valid table entry sets `viol` to 1 and `cause` to 1 on the clock edge that samples the beat.
- R4: A pulse on `tbl_we` writes `tbl_addr` and the valid bit `tbl_en` into entry `tbl_idx`. An entry written with `tbl_en`=0 no longer matches.
- R5: A sequence is closed by a valid beat of kind 2 (return), 3 (indirect jump) or 4 (indirect call), and its length includes that closing beat. A length below the length limit is short. When the chain limit is reached by consecutive short sequences, `viol` goes to 1 with `cause`=2 on the edge that samples the closing beat. The chain counter then restarts from zero.
- R6: A sequence whose length is at least the length limit resets the chain counter to zero.
- R7: The running length counter saturates at the length limit. A long straight-line run, such as 17 non-branch instructions, therefore always counts as not short.
- R8: A pulse on `thr_we` loads `thr_len_in` as the length limit and `thr_cnt_in` as the chain limit, and they apply from the next beat.
- R9: Once `viol` is 1, it and `cause` hold their values through later faults until `clr` is pulsed. They are 0 after the edge that samples `clr`.
- R10: A beat that is both a bad return and the end of a firing chain reports `cause`=1. A fault on a beat sampled together with `clr` is dropped.
- R11: Beats with `tr_valid`=0 change neither the sequence length, nor the chain counter, nor the violation state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tr_valid | input | 1 | Retired-instruction beat is valid |
| tr_kind | input | 3 | 0 other, 1 direct call, 2 return, 3 indirect jump, 4 indirect call, 5 to 7 treated as other |
| tr_target | input | AW | Branch target of the beat |
| tbl_we | input | 1 | Call-site table write strobe |
| tbl_idx | input | $clog2(ENTRIES) | Table entry to write |
| tbl_addr | input | AW | Call-preceded address to store |
| tbl_en | input | 1 | Valid bit stored with the entry |
| thr_we | input | 1 | Limit register write strobe |
| thr_len_in | input | LW | New sequence length limit |
| thr_cnt_in | input | CW | New chain count limit |
| clr | input | 1 | Clears the sticky violation and cause |
| viol | output | 1 | Sticky violation flag |
| cause | output | 2 | 0 none, 1 return to non-call-preceded address, 2 short-sequence chain |

## Verification
The hardest case to reach from the ports is the exact edge of the chain rule. Here the closing beat of the Nth short sequence must be told apart from the beat before it, and a long sequence in the middle of a chain must restart the count. To reach it, the stimulus first forces a known chain state by issuing a run longer than the length limit. It then feeds sequences of length limit minus one, length limit, and a 17-beat straight-line run, and checks the flag after the N-1th and the Nth short sequence. The same sequence setup is used to make a bad return coincide with the chain-ending beat, and to interleave invalid beats in a chain.

// File: rtl/rfg_pkg.sv
package rfg_pkg;
  localparam logic [2:0] KIND_OTHER = 3'd0;
  localparam logic [2:0] KIND_CALL  = 3'd1;
  localparam logic [2:0] KIND_RET   = 3'd2;
  localparam logic [2:0] KIND_IJMP  = 3'd3;
  localparam logic [2:0] KIND_ICALL = 3'd4;

  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'd0,
    CAUSE_BADRET = 2'd1,
    CAUSE_CHAIN  = 2'd2
  } cause_t;

  function automatic logic is_indirect(input logic [2:0] k);
    return (k == KIND_RET) || (k == KIND_IJMP) || (k == KIND_ICALL);
  endfunction
endpackage

// File: rtl/rfg_site_table.sv
module rfg_site_table #(
  parameter int AW      = 32,
  parameter int ENTRIES = 8,
  localparam int IW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [IW-1:0] idx,
  input  logic [AW-1:0] addr,
  input  logic          en,
  input  logic [AW-1:0] lookup,
  output logic          hit
);
  logic [AW-1:0]      site_addr [ENTRIES];
  logic [ENTRIES-1:0] site_ok;
  logic [ENTRIES-1:0] match;

  always_ff @(posedge clk) begin
    if (we) site_addr[idx] <= addr;
  end

  always_ff @(posedge clk) begin
    if (rst)     site_ok      <= '0;
    else if (we) site_ok[idx] <= en;
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = site_ok[g] && (site_addr[g] == lookup);
  end

  assign hit = |match;
endmodule

// File: rtl/rfg_seq_tracker.sv
module rfg_seq_tracker #(
  parameter int LW = 4,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  input  logic          closes,
  input  logic [LW-1:0] len_lim,
  input  logic [CW-1:0] cnt_lim,
  output logic          fire
);
  logic [LW-1:0] run_len;
  logic [CW-1:0] chain;
  logic          short_seq;

  assign short_seq = ({1'b0, run_len} + 1'b1) < {1'b0, len_lim};
  assign fire      = step && closes && short_seq &&
                     (({1'b0, chain} + 1'b1) >= {1'b0, cnt_lim});

  always_ff @(posedge clk) begin
    if (rst) begin
      run_len <= '0;
      chain   <= '0;
    end else if (step) begin
      if (closes) begin
        run_len <= '0;
        if (!short_seq || fire) chain <= '0;
        else                    chain <= chain + 1'b1;
      end else if (run_len < len_lim) begin
        run_len <= run_len + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rfg_top.sv
module rfg_top
  import rfg_pkg::*;
#(
  parameter int AW      = 32,
  parameter int ENTRIES = 8,
  parameter int LW      = 4,
  parameter int CW      = 4,
  parameter int DEF_LEN = 5,
  parameter int DEF_CNT = 8,
  localparam int IW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tr_valid,
  input  logic [2:0]    tr_kind,
  input  logic [AW-1:0] tr_target,
  input  logic          tbl_we,
  input  logic [IW-1:0] tbl_idx,
  input  logic [AW-1:0] tbl_addr,
  input  logic          tbl_en,
  input  logic          thr_we,
  input  logic [LW-1:0] thr_len_in,
  input  logic [CW-1:0] thr_cnt_in,
  input  logic          clr,
  output logic          viol,
  output logic [1:0]    cause
);
  logic [LW-1:0] len_lim;
  logic [CW-1:0] cnt_lim;
  logic          ret_hit;
  logic          chain_fire;
  logic          bad_ret;

  always_ff @(posedge clk) begin
    if (rst) begin
      len_lim <= LW'(DEF_LEN);
      cnt_lim <= CW'(DEF_CNT);
    end else if (thr_we) begin
      len_lim <= thr_len_in;
      cnt_lim <= thr_cnt_in;
    end
  end

  rfg_site_table #(.AW(AW), .ENTRIES(ENTRIES)) u_table (
    .clk(clk), .rst(rst), .we(tbl_we), .idx(tbl_idx), .addr(tbl_addr),
    .en(tbl_en), .lookup(tr_target), .hit(ret_hit)
  );

  rfg_seq_tracker #(.LW(LW), .CW(CW)) u_seq (
    .clk(clk), .rst(rst), .step(tr_valid), .closes(is_indirect(tr_kind)),
    .len_lim(len_lim), .cnt_lim(cnt_lim), .fire(chain_fire)
  );

  assign bad_ret = tr_valid && (tr_kind == KIND_RET) && !ret_hit;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      viol  <= 1'b0;
      cause <= CAUSE_NONE;
    end else if (!viol) begin
      if (bad_ret) begin
        viol  <= 1'b1;
        cause <= CAUSE_BADRET;
      end else if (chain_fire) begin
        viol  <= 1'b1;
        cause <= CAUSE_CHAIN;
      end
    end
  end
endmodule

// File: rtl/rfg_checker.sv
module rfg_checker (
  input logic       clk,
  input logic       rst,
  input logic       tr_valid,
  input logic [2:0] tr_kind,
  input logic       ret_hit,
  input logic       chain_fire,
  input logic       clr,
  input logic       viol,
  input logic [1:0] cause
);
  p_cause_match_r9: assert property (@(posedge clk) disable iff (rst)
    viol == (cause != 2'd0));

  p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (viol && !clr) |=> (viol && $stable(cause)));

  p_clear_r9: assert property (@(posedge clk) disable iff (rst)
    clr |=> !viol);

  p_bad_ret_r3: assert property (@(posedge clk) disable iff (rst)
    (tr_valid && tr_kind == 3'd2 && !ret_hit && !viol && !clr)
      |=> (viol && cause == 2'd1));

  p_good_ret_r2: assert property (@(posedge clk) disable iff (rst)
    (tr_valid && tr_kind == 3'd2 && ret_hit && !chain_fire && !viol)
      |=> !viol);

  p_chain_r5: assert property (@(posedge clk) disable iff (rst)
    (chain_fire && !viol && !clr && !(tr_kind == 3'd2 && !ret_hit))
      |=> (viol && cause == 2'd2));

  p_needs_valid_r11: assert property (@(posedge clk) disable iff (rst)
    $rose(viol) |-> $past(tr_valid));
endmodule

bind rfg_top rfg_checker u_chk (
  .clk(clk), .rst(rst), .tr_valid(tr_valid), .tr_kind(tr_kind),
  .ret_hit(ret_hit), .chain_fire(chain_fire), .clr(clr),
  .viol(viol), .cause(cause)
);

// File: tb/rfg_top_tb_top.sv
module rfg_top_tb_top;
  localparam int AW = 32;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tr_valid = 1'b0;
  logic [2:0] tr_kind = 3'd0;
  logic [AW-1:0] tr_target = '0;
  logic tbl_we = 1'b0;
  logic [2:0] tbl_idx = '0;
  logic [AW-1:0] tbl_addr = '0;
  logic tbl_en = 1'b0;
  logic thr_we = 1'b0;
  logic [3:0] thr_len_in = '0;
  logic [3:0] thr_cnt_in = '0;
  logic clr = 1'b0;
  logic viol;
  logic [1:0] cause;
  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  rfg_top dut_i (
    .clk(clk), .rst(rst), .tr_valid(tr_valid), .tr_kind(tr_kind),
    .tr_target(tr_target), .tbl_we(tbl_we), .tbl_idx(tbl_idx),
    .tbl_addr(tbl_addr), .tbl_en(tbl_en), .thr_we(thr_we),
    .thr_len_in(thr_len_in), .thr_cnt_in(thr_cnt_in), .clr(clr),
    .viol(viol), .cause(cause)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] k, input logic [AW-1:0] t);
    @(negedge clk);
    tr_valid = 1'b1; tr_kind = k; tr_target = t;
    @(posedge clk); #1;
    tr_valid = 1'b0; tr_kind = 3'd0;
  endtask

  task automatic issue_inv(input logic [2:0] k, input logic [AW-1:0] t);
    @(negedge clk);
    tr_valid = 1'b0; tr_kind = k; tr_target = t;
    @(posedge clk); #1;
    tr_kind = 3'd0;
  endtask

  task automatic plain(input int n);
    for (int i = 0; i < n; i++) issue(3'd0, '0);
  endtask

  task automatic shorts(input int n);
    for (int i = 0; i < n; i++) issue(3'd3, 32'h500);
  endtask

  task automatic break_chain();
    plain(5);
    issue(3'd3, 32'h600);
  endtask

  task automatic do_clr();
    @(negedge clk); clr = 1'b1;
    @(posedge clk); #1; clr = 1'b0;
  endtask

  task automatic wr_site(input int idx, input logic [AW-1:0] a, input logic e);
    @(negedge clk);
    tbl_we = 1'b1; tbl_idx = 3'(idx); tbl_addr = a; tbl_en = e;
    @(posedge clk); #1; tbl_we = 1'b0;
  endtask

  task automatic wr_thr(input int s, input int n);
    @(negedge clk);
    thr_we = 1'b1; thr_len_in = 4'(s); thr_cnt_in = 4'(n);
    @(posedge clk); #1; thr_we = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 viol after reset", int'(viol), 0);
    chk("R1 cause after reset", int'(cause), 0);
    break_chain();
    issue(3'd2, 32'h40);
    chk("R1 empty table return viol", int'(viol), 1);
    chk("R3 empty table return cause", int'(cause), 1);
    do_clr();
    chk("R9 clear viol", int'(viol), 0);
    chk("R9 clear cause", int'(cause), 0);
  endtask

  task automatic t_table();
    wr_site(3, 32'h1004, 1'b1);
    wr_site(0, 32'h2000, 1'b1);
    wr_site(7, 32'h3000, 1'b1);
    break_chain();
    issue(3'd2, 32'h1004);
    issue(3'd2, 32'h2000);
    issue(3'd2, 32'h3000);
    chk("R2 legal returns", int'(viol), 0);
    break_chain();
    issue(3'd2, 32'h1008);
    chk("R3 bad return viol", int'(viol), 1);
    chk("R3 bad return cause", int'(cause), 1);
    do_clr();
    wr_site(3, 32'h1004, 1'b0);
    break_chain();
    issue(3'd2, 32'h1004);
    chk("R4 invalidated entry", int'(cause), 1);
    do_clr();
  endtask

  task automatic t_chain();
    break_chain();
    shorts(7);
    chk("R5 seven shorts", int'(viol), 0);
    shorts(1);
    chk("R5 eighth short viol", int'(viol), 1);
    chk("R5 eighth short cause", int'(cause), 2);
    issue(3'd2, 32'h77);
    chk("R9 sticky cause", int'(cause), 2);
    do_clr();
    break_chain();
    for (int i = 0; i < 7; i++) begin plain(3); issue(3'd4, 32'h9); end
    chk("R5 length S-1 x7", int'(viol), 0);
    plain(3); issue(3'd4, 32'h9);
    chk("R5 length S-1 x8", int'(cause), 2);
    do_clr();
    break_chain();
    shorts(7);
    plain(4); issue(3'd3, 32'h9);
    shorts(7);
    chk("R6 length S resets chain", int'(viol), 0);
    shorts(1);
    chk("R6 chain after reset", int'(cause), 2);
    do_clr();
  endtask

  task automatic t_saturate();
    break_chain();
    shorts(7);
    plain(17); issue(3'd3, 32'h9);
    shorts(7);
    chk("R7 long run breaks chain", int'(viol), 0);
    shorts(1);
    chk("R7 chain restarted", int'(cause), 2);
    do_clr();
  endtask

  task automatic t_priority();
    break_chain();
    shorts(7);
    issue(3'd2, 32'hBAD0);
    chk("R10 bad return wins", int'(cause), 1);
    do_clr();
    break_chain();
    @(negedge clk);
    clr = 1'b1; tr_valid = 1'b1; tr_kind = 3'd2; tr_target = 32'hBAD0;
    @(posedge clk); #1;
    clr = 1'b0; tr_valid = 1'b0; tr_kind = 3'd0;
    chk("R10 clear drops fault", int'(viol), 0);
  endtask

  task automatic t_invalid();
    break_chain();
    shorts(7);
    for (int i = 0; i < 5; i++) issue_inv(3'd3, 32'h9);
    issue_inv(3'd2, 32'hBAD0);
    chk("R11 invalid beats ignored", int'(viol), 0);
    shorts(1);
    chk("R11 chain intact", int'(cause), 2);
    do_clr();
  endtask

  task automatic t_thresholds();
    wr_thr(2, 3);
    break_chain();
    shorts(2);
    chk("R8 two shorts", int'(viol), 0);
    plain(1); issue(3'd3, 32'h9);
    shorts(2);
    chk("R8 length two breaks", int'(viol), 0);
    shorts(1);
    chk("R8 new limits fire", int'(cause), 2);
    do_clr();
    wr_thr(5, 8);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_table();
    t_chain();
    t_saturate();
    t_priority();
    t_invalid();
    t_thresholds();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule